// File: doc/BRIEF.md
# Capture Buffer Dump Serializer

This block turns the contents of a sample capture memory into a byte stream for a serial transmitter. Each memory word holds one sample: a 10-bit analog code and an 8-bit logic snapshot. The block packs each sample into three bytes. Only the low six bits of each byte carry payload, and the logic snapshot is split across the second and third bytes. It hands the bytes to the transmitter over a ready/valid handshake.

Once the capture side reports that its data is complete, a dump request starts a transfer. The dump begins at a given read pointer, which is the slot holding the oldest sample relative to the trigger. It walks forward through every slot, wrapping at the end of the memory, and stops after exactly three bytes per slot. The memory is read ahead of the output through a synchronous read port with a configurable latency. Because of this read-ahead, a transmitter that is always ready receives one byte per cycle with no gaps.

Top module: `capdump_serializer`

## Requirements
- R1: A dump request taken while idle with capture-ready high raises busy on the following cycle and starts the reads at the supplied read pointer.
- R2: A dump request while capture-ready is low has no effect: busy, byte valid and memory reads all stay low.
- R3: A dump request while busy is ignored. The running dump keeps its read pointer, its byte order and its length.
- R4: A dump issues exactly DEPTH memory reads. Their addresses are base, base+1, and so on, modulo DEPTH. Reads happen only while busy.
- R5: The first byte of each sample carries analog bits 5:0 in bits 5:0. A memory word holds analog in bits 9:0 and logic in bits 17:10.
- R6: The second byte of each sample carries analog bits 9:6 in bits 3:0 and logic bits 1:0 in bits 5:4.
- R7: The third byte of each sample carries logic bits 7:2 in bits 5:0.
- R8: Bits 7:6 of every output byte are zero.
- R9: A byte is consumed only on a cycle where valid and ready are both high. While valid is high and ready is low, valid and the byte hold unchanged.
- R10: While ready stays high, bytes follow on consecutive cycles from the first byte to the last, with no gap cycles.
- R11: A dump delivers exactly 3*DEPTH bytes. On the cycle after the last byte is accepted, busy and valid are both low.
- R12: After reset, busy, byte valid and memory read enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dump_req_i | input | 1 | Dump request pulse |
| capt_rdy_i | input | 1 | Capture data complete; qualifies dump requests |
| rd_base_i | input | AW | Slot of the oldest sample; the dump starts here |
| mem_rd_en_o | output | 1 | Capture memory read enable |
| mem_rd_addr_o | output | AW | Capture memory read address |
| mem_rd_data_i | input | ANA_W+LOG_W | Read data, RD_LAT cycles after the enable |
| tx_data_o | output | 8 | Packed output byte |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Transmitter accepts byte |
| busy_o | output | 1 | Dump in progress |

## Verification
The read-ahead has two failure modes, and both show up at the ports soon after they occur. A wrong byte-select or sample-hold state puts a byte out of position within a few cycles. A slot count that is off by one changes the byte total or the busy fall time at the end of the dump. An error in the occupancy bookkeeping either drops a gap into an always-ready stream or overwrites a prefetched sample. The overwrite appears as the wrong sample within about three bytes. The sweep covers every start pointer under several stall patterns, so faults in wrap-around and back-pressure are caught within one dump.

// File: rtl/capdump_pkg.sv
package capdump_pkg;

   localparam int PACK_ANA_W = 10;
   localparam int PACK_LOG_W = 8;
   localparam int BYTES_PER_SAMPLE = 3;

   typedef enum logic [1:0] {
      SEL_B0 = 2'd0,
      SEL_B1 = 2'd1,
      SEL_B2 = 2'd2
   } bsel_e;

   // Six payload bits per byte; the upper two stay clear.
   function automatic logic [7:0] pack_byte(input logic [PACK_ANA_W-1:0] ana,
                                            input logic [PACK_LOG_W-1:0] lg,
                                            input bsel_e sel);
      logic [7:0] b;
      case (sel)
         SEL_B0:  b = {2'b00, ana[5:0]};
         SEL_B1:  b = {2'b00, lg[1:0], ana[9:6]};
         SEL_B2:  b = {2'b00, lg[7:2]};
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/capdump_rd_issue.sv
module capdump_rd_issue #(
   parameter int DEPTH = 1024,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_acc,
   input  logic [AW-1:0] base,
   input  logic          issue_ok,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr
);

   logic [AW-1:0] addr_q;
   logic [CW-1:0] left_q;

   assign rd_en   = issue_ok && (left_q != '0);
   assign rd_addr = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
      end else if (start_acc) begin
         addr_q <= base;
         left_q <= CW'(DEPTH);
      end else if (rd_en) begin
         addr_q <= addr_q + AW'(1);
         left_q <= left_q - CW'(1);
      end
   end

endmodule

// File: rtl/capdump_ret_pipe.sv
module capdump_ret_pipe #(
   parameter int RD_LAT = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_en,
   output logic       ret_vld,
   output logic [1:0] inflight
);

   generate
      if (RD_LAT == 1) begin : g_lat1
         logic p_q;
         always_ff @(posedge clk) begin
            if (!rst_n) p_q <= 1'b0;
            else        p_q <= rd_en;
         end
         assign ret_vld  = p_q;
         assign inflight = {1'b0, p_q};
      end else begin : g_latn
         logic [RD_LAT-1:0] p_q;
         always_ff @(posedge clk) begin
            if (!rst_n) p_q <= '0;
            else        p_q <= {p_q[RD_LAT-2:0], rd_en};
         end
         assign ret_vld  = p_q[RD_LAT-1];
         assign inflight = 2'($countones(p_q));
      end
   endgenerate

endmodule

// File: rtl/capdump_stage.sv
module capdump_stage
   import capdump_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int ANA_W = 10,
   parameter int LOG_W = 8,
   localparam int SW = ANA_W + LOG_W,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_acc,
   input  logic          ret_vld,
   input  logic [SW-1:0] ret_data,
   input  logic          ready_i,
   output logic          valid_o,
   output logic [7:0]    byte_o,
   output logic          cur_vld,
   output logic          nxt_vld,
   output logic          fin,
   output logic          last_done
);

   logic [SW-1:0] cur_q, nxt_q;
   logic          cur_vld_q, nxt_vld_q;
   bsel_e         sel_q;
   logic [CW-1:0] left_q;
   logic          accept, cur_free;

   assign accept    = cur_vld_q && ready_i;
   assign fin       = accept && (sel_q == SEL_B2);
   assign cur_free  = !cur_vld_q || fin;
   assign last_done = fin && (left_q == CW'(1));
   assign valid_o   = cur_vld_q;
   assign cur_vld   = cur_vld_q;
   assign nxt_vld   = nxt_vld_q;
   assign byte_o    = pack_byte(cur_q[ANA_W-1:0], cur_q[SW-1:ANA_W], sel_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q     <= '0;
         nxt_q     <= '0;
         cur_vld_q <= 1'b0;
         nxt_vld_q <= 1'b0;
         sel_q     <= SEL_B0;
         left_q    <= '0;
      end else if (start_acc) begin
         cur_vld_q <= 1'b0;
         nxt_vld_q <= 1'b0;
         sel_q     <= SEL_B0;
         left_q    <= CW'(DEPTH);
      end else begin
         if (accept) begin
            case (sel_q)
               SEL_B0:  sel_q <= SEL_B1;
               SEL_B1:  sel_q <= SEL_B2;
               default: sel_q <= SEL_B0;
            endcase
         end
         if (fin) left_q <= left_q - CW'(1);
         if (cur_free) begin
            if (nxt_vld_q) begin
               cur_q     <= nxt_q;
               cur_vld_q <= 1'b1;
               nxt_vld_q <= ret_vld;
               if (ret_vld) nxt_q <= ret_data;
            end else if (ret_vld) begin
               cur_q     <= ret_data;
               cur_vld_q <= 1'b1;
            end else begin
               cur_vld_q <= 1'b0;
            end
         end else if (ret_vld) begin
            nxt_q     <= ret_data;
            nxt_vld_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/capdump_serializer.sv
module capdump_serializer
   import capdump_pkg::*;
#(
   parameter int DEPTH  = 1024,
   parameter int ANA_W  = 10,
   parameter int LOG_W  = 8,
   parameter int RD_LAT = 1,
   localparam int AW = $clog2(DEPTH),
   localparam int SW = ANA_W + LOG_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dump_req_i,
   input  logic          capt_rdy_i,
   input  logic [AW-1:0] rd_base_i,
   output logic          mem_rd_en_o,
   output logic [AW-1:0] mem_rd_addr_o,
   input  logic [SW-1:0] mem_rd_data_i,
   output logic [7:0]    tx_data_o,
   output logic          tx_valid_o,
   input  logic          tx_ready_i,
   output logic          busy_o
);

   generate
      if (ANA_W != PACK_ANA_W) begin : g_bad_ana
         $error("ANA_W must match the fixed three-byte packing");
      end
      if (LOG_W != PACK_LOG_W) begin : g_bad_log
         $error("LOG_W must match the fixed three-byte packing");
      end
      if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (RD_LAT < 1 || RD_LAT > 3) begin : g_bad_lat
         $error("RD_LAT must lie in 1..3 to keep the stream gap-free");
      end
   endgenerate

   logic       busy_q, start_acc, issue_ok, rd_en;
   logic       ret_vld, cur_vld, nxt_vld, fin, last_done;
   logic [1:0] inflight;
   logic [2:0] occ;

   assign start_acc = dump_req_i && capt_rdy_i && !busy_q;
   assign occ       = 3'(cur_vld) + 3'(nxt_vld) + 3'(inflight) - 3'(fin);
   assign issue_ok  = busy_q && (occ < 3'd2);

   always_ff @(posedge clk) begin
      if (!rst_n)         busy_q <= 1'b0;
      else if (start_acc) busy_q <= 1'b1;
      else if (last_done) busy_q <= 1'b0;
   end

   capdump_rd_issue #(.DEPTH(DEPTH)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_acc (start_acc),
      .base      (rd_base_i),
      .issue_ok  (issue_ok),
      .rd_en     (rd_en),
      .rd_addr   (mem_rd_addr_o)
   );

   capdump_ret_pipe #(.RD_LAT(RD_LAT)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .ret_vld  (ret_vld),
      .inflight (inflight)
   );

   capdump_stage #(.DEPTH(DEPTH), .ANA_W(ANA_W), .LOG_W(LOG_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_acc (start_acc),
      .ret_vld   (ret_vld),
      .ret_data  (mem_rd_data_i),
      .ready_i   (tx_ready_i),
      .valid_o   (tx_valid_o),
      .byte_o    (tx_data_o),
      .cur_vld   (cur_vld),
      .nxt_vld   (nxt_vld),
      .fin       (fin),
      .last_done (last_done)
   );

   assign mem_rd_en_o = rd_en;
   assign busy_o      = busy_q;

endmodule

// File: rtl/capdump_serializer_chk.sv
module capdump_serializer_chk #(
   parameter int DEPTH = 1024,
   localparam int AW  = $clog2(DEPTH),
   localparam int BCW = $clog2(3 * DEPTH + 1),
   localparam int RCW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dump_req_i,
   input logic          capt_rdy_i,
   input logic          mem_rd_en_o,
   input logic [AW-1:0] mem_rd_addr_o,
   input logic [7:0]    tx_data_o,
   input logic          tx_valid_o,
   input logic          tx_ready_i,
   input logic          busy_o
);

   logic [BCW-1:0] bytes_q;
   logic [RCW-1:0] reads_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy_o) begin
         bytes_q <= '0;
         reads_q <= '0;
      end else begin
         if (tx_valid_o && tx_ready_i) bytes_q <= bytes_q + BCW'(1);
         if (mem_rd_en_o)              reads_q <= reads_q + RCW'(1);
      end
   end

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && dump_req_i && capt_rdy_i) |=> busy_o); // R1
   AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !(dump_req_i && capt_rdy_i)) |=> !busy_o); // R2
   AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && dump_req_i && !(tx_valid_o && tx_ready_i)) |=> busy_o); // R3
   AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en_o |-> busy_o); // R4
   AST_READ_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (reads_q == RCW'(DEPTH))); // R4
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> (tx_data_o[7:6] == 2'b00)); // R8
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R9
   AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(tx_valid_o && tx_ready_i)) |-> tx_valid_o); // R10
   AST_BYTE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (bytes_q == BCW'(3 * DEPTH))); // R11
   AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> busy_o); // R11

endmodule

bind capdump_serializer capdump_serializer_chk #(.DEPTH(DEPTH)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .dump_req_i    (dump_req_i),
   .capt_rdy_i    (capt_rdy_i),
   .mem_rd_en_o   (mem_rd_en_o),
   .mem_rd_addr_o (mem_rd_addr_o),
   .tx_data_o     (tx_data_o),
   .tx_valid_o    (tx_valid_o),
   .tx_ready_i    (tx_ready_i),
   .busy_o        (busy_o)
);

// File: tb/capdump_serializer_tb_top.sv
module capdump_serializer_tb_top;

   localparam int D   = 16;
   localparam int AW  = 4;
   localparam int LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, rdy = 1'b0, ready = 1'b0;
   logic [AW-1:0] base = '0;
   logic          rd_en, valid, busy;
   logic [AW-1:0] rd_addr;
   logic [17:0]   rd_data, m1_q, m2_q;
   logic [7:0]    data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   capdump_serializer #(.DEPTH(D), .RD_LAT(LAT)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .dump_req_i    (req),
      .capt_rdy_i    (rdy),
      .rd_base_i     (base),
      .mem_rd_en_o   (rd_en),
      .mem_rd_addr_o (rd_addr),
      .mem_rd_data_i (rd_data),
      .tx_data_o     (data),
      .tx_valid_o    (valid),
      .tx_ready_i    (ready),
      .busy_o        (busy)
   );

   function automatic int ana_of(int a);
      return (a * 67 + 3 * a * a + 517) % 1024;
   endfunction

   function automatic int log_of(int a);
      return ((a * 29) ^ 8'h5A) % 256;
   endfunction

   // memory model: word = {logic[7:0], analog[9:0]}, two-cycle read
   always_ff @(posedge clk) begin
      m1_q <= {8'(log_of(int'(rd_addr))), 10'(ana_of(int'(rd_addr)))};
      m2_q <= m1_q;
   end
   assign rd_data = m2_q;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, expv);
      end
   endtask

   function automatic int exp_byte(int b, int idx);
      int a, an, lg;
      a  = (b + idx / 3) % D;
      an = ana_of(a);
      lg = log_of(a);
      case (idx % 3)
         0:       return an & 63;
         1:       return ((lg & 3) << 4) | (an >> 6);
         default: return lg >> 2;
      endcase
   endfunction

   function automatic bit pat(int mode, int c);
      case (mode)
         0:       return 1'b1;
         1:       return (c % 2) == 0;
         2:       return (c % 3) != 2;
         default: return (c % 7) < 2;
      endcase
   endfunction

   task automatic run_dump(input int b, input int mode, input bit inject);
      int cnt = 0, rds = 0, cyc = 0;
      bit seen = 0, hold = 0;
      logic [7:0] hold_d = '0;
      @(negedge clk);
      req = 1'b1; rdy = 1'b1; base = AW'(b);
      @(negedge clk);
      req = 1'b0;
      chk(busy == 1'b1, "R1 busy after request", int'(busy), 1);
      while (cnt < 3 * D && cyc < 3000) begin
         if (rd_en) begin
            chk(int'(rd_addr) == (b + rds) % D, "R4 read address", int'(rd_addr), (b + rds) % D);
            rds++;
         end
         if (hold) begin
            chk(valid && data == hold_d, "R9 hold under stall", int'(data), int'(hold_d));
            hold = 0;
         end
         if (mode == 0 && seen) chk(valid == 1'b1, "R10 no gap", int'(valid), 1);
         ready = pat(mode, cyc);
         if (valid) begin
            seen = 1;
            if (ready) begin
               case (cnt % 3)
                  0:       chk(int'(data) == exp_byte(b, cnt), "R5 byte0", int'(data), exp_byte(b, cnt));
                  1:       chk(int'(data) == exp_byte(b, cnt), "R6 byte1", int'(data), exp_byte(b, cnt));
                  default: chk(int'(data) == exp_byte(b, cnt), "R7 byte2", int'(data), exp_byte(b, cnt));
               endcase
               chk(data[7:6] == 2'b00, "R8 upper bits", int'(data[7:6]), 0);
               cnt++;
            end else begin
               hold = 1;
               hold_d = data;
            end
         end
         if (inject && (cyc == 7 || cyc == 20)) begin
            req = 1'b1;             // R3: ignored while busy
            base = AW'(b + 5);
         end else begin
            req = 1'b0;
         end
         cyc++;
         @(negedge clk);
      end
      ready = 1'b0;
      req = 1'b0;
      chk(cnt == 3 * D, "R11 byte total", cnt, 3 * D);
      chk(busy == 1'b0 && valid == 1'b0, "R11 idle after last", int'({busy, valid}), 0);
      chk(rds == D, "R4 read total", rds, D);
      if (inject) chk(cnt == 3 * D && !busy, "R3 request while busy ignored", cnt, 3 * D);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !valid && !rd_en, "R12 reset state", int'({busy, valid, rd_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: request without capture-ready
      req = 1'b1; rdy = 1'b0; base = AW'(3);
      @(negedge clk);
      req = 1'b0;
      for (int i = 0; i < 6; i++) begin
         chk(!busy && !valid && !rd_en, "R2 request ignored", int'({busy, valid, rd_en}), 0);
         @(negedge clk);
      end
      for (int b = 0; b < D; b++) begin
         for (int m = 0; m < 4; m++) begin
            run_dump(b, m, (b % 3) == 1);
         end
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule